// File: doc/BRIEF.md
# Pipelined Tagged Bitonic Sorter

This block sorts a list of lanes into ascending order by an unsigned key, the voltage. Each lane carries a signed position tag alongside its key. The typical source is a converter arm, where the key is a measured capacitor voltage and the tag is the physical location of that submodule. The comparisons are made on the voltage only. Whenever two voltages are exchanged, their tags are exchanged with them, so each output lane still names the submodule it came from.

The network is a bitonic sorter with `N` lanes, where `N` is a power of two. It has log2(N)·(log2(N)+1)/2 compare-and-swap layers, and each layer ends in a register bank. A fresh list may therefore enter on every clock, with a valid flag travelling beside it.

Fewer than `N` submodules may be present. The caller states how many lanes are live through `in_count`. Every lane at or above that index is replaced, before the first layer, by a filler entry: voltage zero and position −1.

Top module: `tagged_bitonic_sorter`

## Requirements
- R1: While reset is asserted, and afterwards until a list has been accepted, `out_valid` is 0.
- R2: When `out_valid` is 1, the `out_volt` lanes are non-decreasing from lane 0 upward.
- R3: The set of (voltage, position) pairs at the output equals the set of padded pairs at the input, so a tag never separates from its voltage.
- R4: A list accepted with `in_valid` = 1 appears with `out_valid` = 1 exactly 6 clock cycles later for N = 8. In general the delay is the number of layers.
- R5: Lists offered on consecutive cycles come out on consecutive cycles, in the order they were offered, with none dropped.
- R6: Lane i with i ≥ `in_count` is replaced by voltage 0 and position −1 (all ones in the PW-bit field). Whatever is driven on such a lane has no effect on the output.
- R7: `in_count` = 0 yields a list of N filler entries. Any `in_count` ≥ N uses all N lanes as driven.
- R8: Equal voltages are never exchanged. If every lane carries the same voltage, each output lane keeps the position tag of the same input lane.
- R9: While `out_valid` is 0, `out_volt` and `out_pos` keep the last result delivered.
- R10: Cycles with `in_valid` = 0 produce no output cycle with `out_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | The input list on this cycle is to be sorted |
| in_count | input | $clog2(N)+1 | Number of live lanes; higher lanes are replaced by fillers |
| in_volt | input | N·VW | Unsigned voltage per lane, lane i at bits [i·VW +: VW] |
| in_pos | input | N·PW | Signed position tag per lane, lane i at bits [i·PW +: PW] |
| out_valid | output | 1 | The output lists on this cycle are a sorted result |
| out_volt | output | N·VW | Sorted voltages, smallest in lane 0 |
| out_pos | output | N·PW | Position tag paired with each output voltage |

## Verification
The filler assertion relies on live lanes never carrying position −1. Because of that, a −1 at the output can only be a padded lane, and such a lane must carry voltage zero. The latency and hold assertions count time from the internally synchronised reset, so they take no interest in the cycles before the first clock edge. The stimulus always gives live lanes non-negative tags. It deliberately drives large voltages and −1 tags onto the masked lanes, so that any leak through the padding would surface in the sorted order or in the pairing check.

// File: rtl/tsort_pkg.sv
package tsort_pkg;

  // Number of compare-and-swap layers for 2**lg lanes.
  function automatic int layer_total(input int lg);
    return lg * (lg + 1) / 2;
  endfunction

  // log2 of the bitonic block size that layer s works on.
  function automatic int layer_block_lg(input int lg, input int s);
    int idx;
    int res;
    idx = 0;
    res = lg;
    for (int p = 1; p <= lg; p++) begin
      for (int q = p - 1; q >= 0; q--) begin
        if (idx == s) res = p;
        idx++;
      end
    end
    return res;
  endfunction

  // log2 of the lane distance between the partners in layer s.
  function automatic int layer_dist_lg(input int lg, input int s);
    int idx;
    int res;
    idx = 0;
    res = 0;
    for (int p = 1; p <= lg; p++) begin
      for (int q = p - 1; q >= 0; q--) begin
        if (idx == s) res = q;
        idx++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/tsort_rst_sync.sv
module tsort_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tsort_cas_cell.sv
// One compare-and-swap cell: one key comparison steering four multiplexers.
module tsort_cas_cell #(
  parameter int VW     = 12,
  parameter int PW     = 5,
  parameter bit ASCEND = 1'b1
) (
  input  logic [VW-1:0] a_volt,
  input  logic [PW-1:0] a_pos,
  input  logic [VW-1:0] b_volt,
  input  logic [PW-1:0] b_pos,
  output logic [VW-1:0] lo_volt,
  output logic [PW-1:0] lo_pos,
  output logic [VW-1:0] hi_volt,
  output logic [PW-1:0] hi_pos
);

  logic swap;

  // Strict comparison: equal keys stay where they are.
  generate
    if (ASCEND) begin : g_up
      assign swap = (a_volt > b_volt);
    end else begin : g_down
      assign swap = (a_volt < b_volt);
    end
  endgenerate

  assign lo_volt = swap ? b_volt : a_volt;
  assign lo_pos  = swap ? b_pos  : a_pos;
  assign hi_volt = swap ? a_volt : b_volt;
  assign hi_pos  = swap ? a_pos  : b_pos;

endmodule

// File: rtl/tsort_stage.sv
// One layer of compare-and-swap cells followed by its register bank.
module tsort_stage #(
  parameter int N       = 8,
  parameter int VW      = 12,
  parameter int PW      = 5,
  parameter int BLK_LG  = 1,
  parameter int DIST_LG = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [N*VW-1:0] volt_i,
  input  logic [N*PW-1:0] pos_i,
  output logic          vld_o,
  output logic [N*VW-1:0] volt_o,
  output logic [N*PW-1:0] pos_o
);

  localparam int DIST = 1 << DIST_LG;

  logic [VW-1:0] nxt_volt [N];
  logic [PW-1:0] nxt_pos  [N];
  logic [N*VW-1:0] nxt_volt_flat;
  logic [N*PW-1:0] nxt_pos_flat;

  generate
    for (genvar i = 0; i < N; i++) begin : g_lane
      if (((i >> DIST_LG) & 1) == 0) begin : g_pair
        localparam int  J  = i + DIST;
        localparam bit UP = (((i >> BLK_LG) & 1) == 0);
        tsort_cas_cell #(
          .VW     (VW),
          .PW     (PW),
          .ASCEND (UP)
        ) u_cell (
          .a_volt  (volt_i[i*VW +: VW]),
          .a_pos   (pos_i[i*PW +: PW]),
          .b_volt  (volt_i[J*VW +: VW]),
          .b_pos   (pos_i[J*PW +: PW]),
          .lo_volt (nxt_volt[i]),
          .lo_pos  (nxt_pos[i]),
          .hi_volt (nxt_volt[J]),
          .hi_pos  (nxt_pos[J])
        );
      end
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < N; k++) begin
      nxt_volt_flat[k*VW +: VW] = nxt_volt[k];
      nxt_pos_flat[k*PW +: PW]  = nxt_pos[k];
    end
  end

  // Valid flag: reset, always clocked.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_i;
  end

  // Data bank: loads only when a list is present.
  always_ff @(posedge clk) begin
    if (vld_i) begin
      volt_o <= nxt_volt_flat;
      pos_o  <= nxt_pos_flat;
    end
  end

endmodule

// File: rtl/tagged_bitonic_sorter.sv
module tagged_bitonic_sorter #(
  parameter int N  = 8,
  parameter int VW = 12,
  parameter int PW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [$clog2(N):0]   in_count,
  input  logic [N*VW-1:0]      in_volt,
  input  logic [N*PW-1:0]      in_pos,
  output logic                 out_valid,
  output logic [N*VW-1:0]      out_volt,
  output logic [N*PW-1:0]      out_pos
);

  import tsort_pkg::*;

  localparam int LG   = $clog2(N);
  localparam int CW   = LG + 1;
  localparam int NSTG = layer_total(LG);

  logic rst_sync_n;

  logic                vchain [NSTG+1];
  logic [N*VW-1:0]     dchain [NSTG+1];
  logic [N*PW-1:0]     pchain [NSTG+1];

  tsort_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Replace lanes at or above in_count with fillers (voltage 0, position -1).
  always_comb begin
    for (int k = 0; k < N; k++) begin
      if (CW'(k) < in_count) begin
        dchain[0][k*VW +: VW] = in_volt[k*VW +: VW];
        pchain[0][k*PW +: PW] = in_pos[k*PW +: PW];
      end else begin
        dchain[0][k*VW +: VW] = '0;
        pchain[0][k*PW +: PW] = '1;
      end
    end
  end

  assign vchain[0] = in_valid;

  generate
    for (genvar s = 0; s < NSTG; s++) begin : g_layer
      tsort_stage #(
        .N       (N),
        .VW      (VW),
        .PW      (PW),
        .BLK_LG  (layer_block_lg(LG, s)),
        .DIST_LG (layer_dist_lg(LG, s))
      ) u_stage (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .vld_i  (vchain[s]),
        .volt_i (dchain[s]),
        .pos_i  (pchain[s]),
        .vld_o  (vchain[s+1]),
        .volt_o (dchain[s+1]),
        .pos_o  (pchain[s+1])
      );
    end
  endgenerate

  assign out_valid = vchain[NSTG];
  assign out_volt  = dchain[NSTG];
  assign out_pos   = pchain[NSTG];

endmodule

// File: rtl/tsort_checker.sv
module tsort_checker #(
  parameter int N  = 8,
  parameter int VW = 12,
  parameter int PW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic [N*VW-1:0] out_volt,
  input logic [N*PW-1:0] out_pos
);

  import tsort_pkg::*;

  localparam int NSTG = layer_total($clog2(N));

  logic [NSTG-1:0] accept_hist;
  logic            seen_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_hist <= '0;
      seen_out    <= 1'b0;
    end else begin
      accept_hist <= {accept_hist[NSTG-2:0], in_valid};
      if (out_valid) seen_out <= 1'b1;
    end
  end

  // R1 / R4 / R10: output valid follows input valid after exactly NSTG cycles.
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == accept_hist[NSTG-1]);

  a_r1_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_out && !accept_hist[NSTG-1] |-> !out_valid);

  // R9: output lanes hold between results.
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seen_out && !out_valid |-> $stable(out_volt) && $stable(out_pos));

  generate
    for (genvar g = 0; g < N; g++) begin : g_chk
      // R6: a filler tag at the output is always paired with voltage zero.
      a_r6_filler_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_pos[g*PW +: PW] == {PW{1'b1}}) |-> out_volt[g*VW +: VW] == '0);
      if (g < N - 1) begin : g_ord
        // R2: ascending order across adjacent lanes.
        a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> out_volt[g*VW +: VW] <= out_volt[(g+1)*VW +: VW]);
      end
    end
  endgenerate

endmodule

bind tagged_bitonic_sorter tsort_checker #(
  .N  (N),
  .VW (VW),
  .PW (PW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_volt  (out_volt),
  .out_pos   (out_pos)
);

// File: tb/tagged_bitonic_sorter_test.sv
`timescale 1ns/1ps
module tagged_bitonic_sorter_test;

  localparam int N    = 8;
  localparam int VW   = 12;
  localparam int PW   = 5;
  localparam int CW   = 4;
  localparam int NSTG = 6;

  typedef struct packed {
    logic [N*VW-1:0] v;
    logic [N*PW-1:0] p;
    int              issue;
    bit              exact;
  } exp_t;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [CW-1:0]   in_count;
  logic [N*VW-1:0] in_volt;
  logic [N*PW-1:0] in_pos;
  logic            out_valid;
  logic [N*VW-1:0] out_volt;
  logic [N*PW-1:0] out_pos;

  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  bit   done   = 0;
  exp_t sb[$];
  logic [N*VW-1:0] last_v;
  logic [N*PW-1:0] last_p;

  tagged_bitonic_sorter #(.N(N), .VW(VW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_count(in_count),
    .in_volt(in_volt), .in_pos(in_pos), .out_valid(out_valid),
    .out_volt(out_volt), .out_pos(out_pos)
  );

  initial clk = 0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string msg,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  function automatic bit same_pairs(input logic [N*VW-1:0] av, input logic [N*PW-1:0] ap,
                                    input logic [N*VW-1:0] bv, input logic [N*PW-1:0] bp);
    for (int i = 0; i < N; i++) begin
      int ca = 0;
      int cb = 0;
      for (int j = 0; j < N; j++) begin
        if (av[j*VW +: VW] == av[i*VW +: VW] && ap[j*PW +: PW] == ap[i*PW +: PW]) ca++;
        if (bv[j*VW +: VW] == av[i*VW +: VW] && bp[j*PW +: PW] == ap[i*PW +: PW]) cb++;
      end
      if (ca != cb) return 0;
    end
    return 1;
  endfunction

  // Driver: offer one list and push its expected result.
  task automatic send(input logic [N*VW-1:0] v, input logic [N*PW-1:0] p, input int cnt);
    int   ev [N];
    int   ep [N];
    exp_t e;
    bit   distinct;
    bit   alleq;
    @(negedge clk);
    in_valid = 1;
    in_count = CW'(cnt);
    in_volt  = v;
    in_pos   = p;
    for (int i = 0; i < N; i++) begin
      if (i < cnt) begin ev[i] = int'(v[i*VW +: VW]); ep[i] = int'(p[i*PW +: PW]); end
      else         begin ev[i] = 0; ep[i] = (1 << PW) - 1; end
    end
    distinct = 1;
    alleq    = 1;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        if (i != j && ev[i] == ev[j]) distinct = 0;
        if (ev[i] != ev[j]) alleq = 0;
      end
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0 && ev[j-1] > ev[j]; j--) begin
        int tv = ev[j]; int tp = ep[j];
        ev[j] = ev[j-1]; ep[j] = ep[j-1];
        ev[j-1] = tv;   ep[j-1] = tp;
      end
    for (int i = 0; i < N; i++) begin
      e.v[i*VW +: VW] = VW'(ev[i]);
      e.p[i*PW +: PW] = PW'(ep[i]);
    end
    e.issue = cyc;
    e.exact = distinct || alleq;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      in_volt  = '1;
    end
  endtask

  // Monitor: pop and compare at each valid output.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (sb.size() == 0) begin
        check(0, "R10", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_volt == e.v, "R2", "voltage order", out_volt, e.v);
        check(same_pairs(out_volt, out_pos, e.v, e.p), "R3", "voltage/tag pairing", out_pos, e.p);
        check(cyc - e.issue == NSTG, "R4", "latency", cyc - e.issue, NSTG);
        if (e.exact) check(out_pos == e.p, "R8", "tag placement", out_pos, e.p);
      end
      last_v = out_volt;
      last_p = out_pos;
    end
  end

  function automatic logic [N*VW-1:0] lcg_volts(input int seed);
    logic [N*VW-1:0] r;
    int s;
    s = seed;
    for (int i = 0; i < N; i++) begin
      s = s * 1103515245 + 12345;
      r[i*VW +: VW] = VW'((s >>> 8) & 32'hFFF);
    end
    return r;
  endfunction

  function automatic logic [N*PW-1:0] tags();
    logic [N*PW-1:0] r;
    for (int i = 0; i < N; i++) r[i*PW +: PW] = PW'(i + 3);
    return r;
  endfunction

  initial begin
    logic [N*VW-1:0] v;
    logic [N*PW-1:0] p;
    rst_n = 0; in_valid = 0; in_count = 0; in_volt = '0; in_pos = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1", "valid during reset", out_valid, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(out_valid == 0, "R1", "valid after reset", out_valid, 0);

    // R2/R3: descending input
    for (int i = 0; i < N; i++) v[i*VW +: VW] = VW'(4000 - 100 * i);
    send(v, tags(), N);
    // ascending input
    for (int i = 0; i < N; i++) v[i*VW +: VW] = VW'(10 + 7 * i);
    send(v, tags(), N);
    // pseudo-random inputs
    send(lcg_volts(17), tags(), N);
    send(lcg_volts(99), tags(), N);
    // R6: only three lanes live, the others carry junk
    v = '1;
    p = '1;
    v[0 +: VW] = 12'd500; p[0 +: PW] = 5'd2;
    v[VW +: VW] = 12'd20; p[PW +: PW] = 5'd9;
    v[2*VW +: VW] = 12'd300; p[2*PW +: PW] = 5'd0;
    send(v, p, 3);
    // R7: none live, and count above N
    send(lcg_volts(5), tags(), 0);
    send(lcg_volts(6), tags(), 12);
    idle(2);
    // R8: all equal voltages keep lane order of tags
    for (int i = 0; i < N; i++) v[i*VW +: VW] = 12'd777;
    send(v, tags(), N);
    // R5: burst of back-to-back lists
    for (int k = 0; k < 10; k++) send(lcg_volts(1000 + k), tags(), 1 + (k % N));
    // R10: sparse offers
    for (int k = 0; k < 4; k++) begin
      send(lcg_volts(50 + k), tags(), N);
      idle(k + 1);
    end
    idle(NSTG + 4);
    check(sb.size() == 0, "R5", "all lists delivered", sb.size(), 0);
    // R9: outputs hold the last result while idle
    check(out_volt == last_v && out_pos == last_p, "R9", "hold after drain",
          out_volt, last_v);
    check(out_valid == 0, "R10", "idle output", out_valid, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule